// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Merge

This block keeps one control and status word for each channel of a multi-channel DMA controller. Software writes a word through a simple 32-bit write port that selects a channel by number. The transfer engine reports per-channel events as one-cycle pulses: start, end, end-of-receive, request-after-stop and stopped. Each bit of the word has its own write rule. Some bits are cleared by writing 1, some are loaded from the written value, some act only as strobes, and the stopped flag follows the run control.

The block reads back the word of one selected channel. It also builds a summary word with one bit per channel and drives a single level-sensitive interrupt line. A write that starts a channel produces a one-cycle pulse toward the engine. That pulse either asks for a descriptor fetch first or starts the channel directly, depending on the no-fetch control bit.

Top module: `dma_chan_status`

## Requirements
- R1: After reset every channel's word reads 0x0000_0008 (only the stopped flag at bit 3 set), the summary word is 0 and the interrupt output is low.
- R2: Writing 1 to bit 1 (start flag), bit 2 (end flag) or bit 9 (end-of-receive flag) clears that flag; writing 0 leaves it unchanged. Bit 0 (bus error) always reads 0.
- R3: Bits 31:26 and bit 23 are loaded from every write. Bit 22 (mask-run), bit 24 (compare-clear strobe) and bit 25 (compare-set strobe) are not stored and read 0.
- R4: A write with bit 31 (run) set clears the stopped flag. If bit 30 (no-fetch) is also 1, it pulses `start_go` for that channel; otherwise it pulses `fetch_req`. Either pulse is high in the cycle after the write edge.
- R5: A write with both run (31) and mask-run (22) at 0 sets the stopped flag (bit 3). A write with run 0 and mask-run 1 leaves it unchanged.
- R6: Bit 24 written as 1 clears the compare flag (bit 10) and bit 25 written as 1 sets it. When both are 1, set wins.
- R7: Bit 8 is not stored and reads 1 exactly while that channel's `req_active` input is high.
- R8: The stopped flag counts as an interrupt cause only while bit 29 is set. The end-of-receive flag needs bit 28, and the request-after-stop flag (bit 4) needs bit 23.
- R9: The start and end flags count as interrupt causes with no enable bit.
- R10: Summary bit i is the OR of channel i's qualified causes, and `irq` is high exactly while any summary bit is set.
- R11: When an engine event sets a flag in the same cycle that a write would clear it, the flag ends up set.
- R12: The request-after-stop flag is set by its engine event and is cleared by a write with run set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected channel word |
| wr_chan | input | CHW | Channel selected for a write |
| wr_data | input | 32 | Value written |
| rd_chan | input | CHW | Channel whose word is returned on `rd_data` |
| rd_data | output | 32 | Registered word of channel `rd_chan` |
| ev_start | input | NCH | Engine pulse: channel started |
| ev_end | input | NCH | Engine pulse: transfer finished |
| ev_eor | input | NCH | Engine pulse: end of receive |
| ev_ras | input | NCH | Engine pulse: request arrived after stop |
| ev_stop | input | NCH | Engine pulse: channel stopped |
| req_active | input | NCH | Live peripheral request per channel |
| start_go | output | NCH | Pulse: start channel without a descriptor fetch |
| fetch_req | output | NCH | Pulse: fetch a descriptor, then start |
| summary | output | NCH | Registered per-channel interrupt summary |
| irq | output | 1 | Registered combined interrupt level |

## Verification
A write or an event updates the channel's flags on the clock edge that samples it. `rd_data`, `summary` and `irq` are registered from those flags, so they show the new value one edge later. `start_go` and `fetch_req` appear right after the write edge. Stimulus is applied on the falling edge. Each scenario task reads back a channel by setting `rd_chan` on one falling edge and sampling on the next, which places exactly one rising edge after the last flag update. The start and fetch pulses are sampled on the falling edge that follows the write edge. Same-cycle collisions are made by driving a write and an event on the same falling edge.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  // bit positions of the channel word
  localparam int B_BERR    = 0;
  localparam int B_START   = 1;
  localparam int B_END     = 2;
  localparam int B_STOP    = 3;
  localparam int B_RAS     = 4;
  localparam int B_REQ     = 8;
  localparam int B_EOR     = 9;
  localparam int B_CMP     = 10;
  localparam int B_MASKRUN = 22;
  localparam int B_RASEN   = 23;
  localparam int B_CMPCLR  = 24;
  localparam int B_CMPSET  = 25;
  localparam int B_CTL_LO  = 26;
  localparam int B_EOREN   = 28;
  localparam int B_STOPEN  = 29;
  localparam int B_NOFETCH = 30;
  localparam int B_RUN     = 31;
  localparam int CTL_W     = 6;   // bits 31:26 stored as one field

  typedef struct packed {
    logic [CTL_W-1:0] ctl;      // loaded bits 31:26
    logic             ras_en;   // loaded bit 23
    logic             run;
    logic             nofetch;
    logic             halt;     // run and mask-run both 0
    logic             clr_start;
    logic             clr_end;
    logic             clr_eor;
    logic             cmp_clr;
    logic             cmp_set;
  } wr_act_t;
endpackage

// File: rtl/dcs_wr_decode.sv
module dcs_wr_decode
  import dcs_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_chan,
  input  logic [31:0]    wr_data,
  output logic [NCH-1:0] sel,
  output wr_act_t        act
);
  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign sel[i] = wr_en && (wr_chan == CHW'(i));
  end

  always_comb begin
    act.ctl       = wr_data[B_RUN:B_CTL_LO];
    act.ras_en    = wr_data[B_RASEN];
    act.run       = wr_data[B_RUN];
    act.nofetch   = wr_data[B_NOFETCH];
    act.halt      = !wr_data[B_RUN] && !wr_data[B_MASKRUN];
    act.clr_start = wr_data[B_START];
    act.clr_end   = wr_data[B_END];
    act.clr_eor   = wr_data[B_EOR];
    act.cmp_clr   = wr_data[B_CMPCLR];
    act.cmp_set   = wr_data[B_CMPSET];
  end
endmodule

// File: rtl/dcs_chan_reg.sv
module dcs_chan_reg
  import dcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sel,
  input  wr_act_t     act,
  input  logic        e_start,
  input  logic        e_end,
  input  logic        e_eor,
  input  logic        e_ras,
  input  logic        e_stop,
  input  logic        req,
  output logic [31:0] word,
  output logic        qual,
  output logic        go_q,
  output logic        fetch_q
);
  logic [CTL_W-1:0] ctl_q;
  logic ras_en_q, start_f, end_f, stop_f, ras_f, eor_f, cmp_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      ras_en_q <= 1'b0;
      start_f  <= 1'b0;
      end_f    <= 1'b0;
      stop_f   <= 1'b1;
      ras_f    <= 1'b0;
      eor_f    <= 1'b0;
      cmp_f    <= 1'b0;
      go_q     <= 1'b0;
      fetch_q  <= 1'b0;
    end else begin
      if (sel) begin
        ctl_q    <= act.ctl;
        ras_en_q <= act.ras_en;
      end
      // engine events take priority over software clears
      if (e_start)                     start_f <= 1'b1;
      else if (sel && act.clr_start)   start_f <= 1'b0;
      if (e_end)                       end_f <= 1'b1;
      else if (sel && act.clr_end)     end_f <= 1'b0;
      if (e_eor)                       eor_f <= 1'b1;
      else if (sel && act.clr_eor)     eor_f <= 1'b0;
      if (e_stop)                      stop_f <= 1'b1;
      else if (sel && act.run)         stop_f <= 1'b0;
      else if (sel && act.halt)        stop_f <= 1'b1;
      if (e_ras)                       ras_f <= 1'b0 | 1'b1;
      else if (sel && act.run)         ras_f <= 1'b0;
      if (sel && act.cmp_set)          cmp_f <= 1'b1;
      else if (sel && act.cmp_clr)     cmp_f <= 1'b0;
      go_q    <= sel && act.run && act.nofetch;
      fetch_q <= sel && act.run && !act.nofetch;
    end
  end

  always_comb begin
    word            = '0;
    word[B_START]   = start_f;
    word[B_END]     = end_f;
    word[B_STOP]    = stop_f;
    word[B_RAS]     = ras_f;
    word[B_REQ]     = req;
    word[B_EOR]     = eor_f;
    word[B_CMP]     = cmp_f;
    word[B_RASEN]   = ras_en_q;
    word[B_RUN:B_CTL_LO] = ctl_q;
  end

  assign qual = (stop_f && ctl_q[B_STOPEN-B_CTL_LO])
              || (eor_f && ctl_q[B_EOREN-B_CTL_LO])
              || (ras_f && ras_en_q)
              || start_f || end_f;

  // R11
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    e_start |=> start_f);
  // R5
  halt_sets_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && act.halt) |=> stop_f);
  // R4
  run_clears_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && act.run && !e_stop) |=> !stop_f);
  // R6
  cmp_set_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && act.cmp_set) |=> cmp_f);
  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(go_q && fetch_q));
endmodule

// File: rtl/dcs_irq_merge.sv
module dcs_irq_merge #(
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0][31:0]  words,
  input  logic [NCH-1:0]        qual,
  input  logic [CHW-1:0]        rd_chan,
  output logic [31:0]           rd_data,
  output logic [NCH-1:0]        summary,
  output logic                  irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      summary <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= words[rd_chan];
      summary <= qual;
      irq     <= |qual;
    end
  end

  // R10
  irq_summary_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (summary != '0));
  // R10
  summary_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (qual == '0) |=> !irq);
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dcs_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_chan,
  input  logic [31:0]    wr_data,
  input  logic [CHW-1:0] rd_chan,
  output logic [31:0]    rd_data,
  input  logic [NCH-1:0] ev_start,
  input  logic [NCH-1:0] ev_end,
  input  logic [NCH-1:0] ev_eor,
  input  logic [NCH-1:0] ev_ras,
  input  logic [NCH-1:0] ev_stop,
  input  logic [NCH-1:0] req_active,
  output logic [NCH-1:0] start_go,
  output logic [NCH-1:0] fetch_req,
  output logic [NCH-1:0] summary,
  output logic           irq
);
  logic [NCH-1:0]       sel;
  wr_act_t              act;
  logic [NCH-1:0][31:0] words;
  logic [NCH-1:0]       qual;

  dcs_wr_decode #(.NCH(NCH)) u_dec (
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
    .sel(sel), .act(act)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dcs_chan_reg u_ch (
      .clk(clk), .rst(rst), .sel(sel[i]), .act(act),
      .e_start(ev_start[i]), .e_end(ev_end[i]), .e_eor(ev_eor[i]),
      .e_ras(ev_ras[i]), .e_stop(ev_stop[i]), .req(req_active[i]),
      .word(words[i]), .qual(qual[i]),
      .go_q(start_go[i]), .fetch_q(fetch_req[i])
    );
  end

  dcs_irq_merge #(.NCH(NCH)) u_irq (
    .clk(clk), .rst(rst), .words(words), .qual(qual), .rd_chan(rd_chan),
    .rd_data(rd_data), .summary(summary), .irq(irq)
  );
endmodule

// File: tb/dma_chan_status_bench.sv
module dma_chan_status_bench;
  localparam int NCH = 16;
  localparam int CHW = $clog2(NCH);
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [CHW-1:0] wr_chan = '0, rd_chan = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NCH-1:0] ev_start = '0, ev_end = '0, ev_eor = '0, ev_ras = '0, ev_stop = '0;
  logic [NCH-1:0] req_active = '0, start_go, fetch_req, summary;
  logic irq;
  logic [NCH-1:0] go_seen, fetch_seen;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  dma_chan_status #(.NCH(NCH)) u_dma_chan_status (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = CHW'(ch); wr_data = d;
    @(negedge clk);
    go_seen = start_go; fetch_seen = fetch_req;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(ref logic [NCH-1:0] v, input int ch);
    @(negedge clk);
    v[ch] = 1'b1;
    @(negedge clk);
    v[ch] = 1'b0;
  endtask

  task automatic rd(int ch, output logic [31:0] d);
    @(negedge clk);
    rd_chan = CHW'(ch);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d);  check("R1 ch0", d, 32'h8);
    rd(15, d); check("R1 ch15", d, 32'h8);
    check("R1 summary", 32'(summary), 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_control();
    logic [31:0] d;
    wr(2, 32'hFFFF_FFFF);
    check("R4 go ch2", 32'(go_seen), 32'h4);
    check("R4 no fetch", 32'(fetch_seen), 0);
    rd(2, d); check("R3 load and strobes", d, 32'hFC80_0400);
    check("R8 stop gated", 32'(summary), 0);
    wr(2, 32'h0040_0000);
    rd(2, d); check("R5 maskrun keeps stop", d, 32'h0000_0400);
    wr(2, 32'h0);
    rd(2, d); check("R5 halt sets stop", d, 32'h0000_0408);
    wr(2, 32'h0100_0000);
    rd(2, d); check("R6 cmp clear", d, 32'h0000_0008);
    wr(3, 32'h8000_0000);
    check("R4 fetch ch3", 32'(fetch_seen), 32'h8);
    check("R4 no go", 32'(go_seen), 0);
    rd(3, d); check("R4 run clears stop", d, 32'h8000_0000);
  endtask

  task automatic t_req();
    logic [31:0] d;
    @(negedge clk); req_active[5] = 1'b1;
    rd(5, d); check("R7 req high", d, 32'h108);
    @(negedge clk); req_active[5] = 1'b0;
    rd(5, d); check("R7 req low", d, 32'h8);
  endtask

  task automatic t_ungated();
    logic [31:0] d;
    pulse(ev_start, 6);
    rd(6, d); check("R9 start flag", d, 32'h0A);
    check("R9 start irq", 32'(irq), 1);
    check("R10 summary bit6", 32'(summary), 32'h40);
    pulse(ev_end, 12);
    rd(12, d); check("R10 two channels", 32'(summary), 32'h1040);
    wr(6, 32'h0040_0002);
    rd(6, d); check("R2 clear start", d, 32'h08);
    check("R10 summary after clear", 32'(summary), 32'h1000);
    wr(12, 32'h0040_0000);
    rd(12, d); check("R2 zero leaves end", d, 32'h0C);
    wr(12, 32'h0040_0004);
    rd(12, d); check("R2 clear end", d, 32'h08);
    check("R10 irq low", 32'(irq), 0);
  endtask

  task automatic t_gated();
    logic [31:0] d;
    pulse(ev_eor, 7);
    rd(7, d); check("R8 eor flag", d, 32'h208);
    check("R8 eor gated", 32'(summary), 0);
    wr(7, 32'h1040_0000);
    rd(7, d); check("R8 eor enabled", 32'(summary), 32'h80);
    wr(7, 32'h1040_0200);
    rd(7, d); check("R2 clear eor", d, 32'h1000_0008);
    check("R2 eor summary", 32'(summary), 0);
    wr(8, 32'h2040_0000);
    rd(8, d); check("R8 stop enabled", 32'(summary), 32'h100);
    wr(8, 32'h0040_0000);
    rd(8, d); check("R8 stop disabled", 32'(summary), 0);
    pulse(ev_ras, 9);
    rd(9, d); check("R12 ras flag", d, 32'h18);
    check("R8 ras gated", 32'(summary), 0);
    wr(9, 32'h00C0_0000);
    rd(9, d); check("R8 ras enabled", 32'(summary), 32'h200);
    wr(9, 32'hC080_0000);
    rd(9, d); check("R12 run clears ras", d, 32'hC080_0000);
    check("R12 summary", 32'(summary), 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(ev_start, 10);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = CHW'(10); wr_data = 32'h0040_0002; ev_start[10] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ev_start[10] = 1'b0;
    rd(10, d); check("R11 start kept", d, 32'h0A);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = CHW'(11); wr_data = 32'hC000_0000; ev_stop[11] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ev_stop[11] = 1'b0;
    rd(11, d); check("R11 stop kept", d, 32'hC000_0008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_control();
    t_req();
    t_ungated();
    t_gated();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule